// File: doc/BRIEF.md
# Balanced-Trit Byte Codec

This block converts between groups of balanced-ternary digits and bytes. It has two channels that share nothing but the clock and reset. The pack channel accepts a group of five trits and returns one byte. The unpack channel accepts one byte and returns a group of five trits.

Each trit carries a 2-bit code. The packed byte is the base-3 number formed by the offset digits of the group. Because five trits cover only 243 of the 256 byte values, the codec flags byte values outside that range when unpacking. When packing, it flags any trit that uses the spare 2-bit code.

Every side uses a valid/ready handshake. Each channel holds its result in a single-entry register. A new group or byte is accepted only when that register is empty or is handing its content over in the same cycle. Stalling one channel therefore never affects the other. Host traffic that moves trits in multiples of five can be streamed through the codec one group per handshake.

Top module: `tcodec_bridge`

## Requirements
- R1: Trit i of a group sits at bits [2i+1:2i]. Code 00 means -1, 01 means 0 and 10 means +1, and each code maps to digit 0, 1 or 2 respectively. For a legal group the packed byte is the base-3 value of the digits, with trit 0 as the most significant digit. The error flag is 0, and the byte is therefore never above 242.
- R2: If any trit of a pack group carries code 11, the pack result has its error flag set to 1 and its byte forced to 0.
- R3: For an input byte in 0..242, the unpack result is the unique legal group whose packed value equals that byte, with the error flag at 0 and no trit at code 11.
- R4: For an input byte in 243..255, the unpack result has its error flag set to 1 and every trit set to code 01.
- R5: While an output is valid and not accepted, it stays valid and its data and flag do not change.
- R6: Results leave in acceptance order, with none lost or repeated. An input is refused while the channel's result register holds an unaccepted result, and it is accepted whenever that register is empty.
- R7: A stalled output on one channel does not stop the other channel from accepting and delivering.
- R8: While reset is asserted, and in the first cycle after it, both output valids are 0.
- R9: An input accepted by an empty channel appears at that channel's output in the cycle after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tg_in_valid | input | 1 | Pack input group valid |
| tg_in_ready | output | 1 | Pack input may be accepted |
| tg_in | input | 2*TRITS | Trit group to pack |
| byte_out_valid | output | 1 | Packed byte valid |
| byte_out_ready | input | 1 | Consumer takes the packed byte |
| byte_out | output | BYTE_W | Packed byte |
| byte_out_err | output | 1 | Group held an illegal trit code |
| byte_in_valid | input | 1 | Byte to unpack valid |
| byte_in_ready | output | 1 | Unpack input may be accepted |
| byte_in | input | BYTE_W | Byte to unpack |
| tg_out_valid | output | 1 | Unpacked group valid |
| tg_out_ready | input | 1 | Consumer takes the group |
| tg_out | output | 2*TRITS | Unpacked trit group |
| tg_out_err | output | 1 | Byte was above the largest group code |

## Verification
The hardest state to reach is one channel held full for many cycles while the other keeps moving. Reaching it needs the pack consumer to hold ready low while a second group waits at the pack input and a stream of bytes runs through unpack. The stimulus forces the pack output ready to 0, parks a group on the full channel and drives twenty unpack transfers. It then releases the stall and sweeps every legal group and every byte value under irregular ready patterns, so that results are repeatedly held against backpressure.

// File: rtl/tcodec_pkg.sv
package tcodec_pkg;

   // 2-bit trit encoding used on the trit side of the codec
   typedef enum logic [1:0] {
      TC_NEG  = 2'b00,
      TC_ZERO = 2'b01,
      TC_POS  = 2'b10,
      TC_BAD  = 2'b11
   } tcode_e;

   // unpack implementation selector
   localparam int UNPK_DIVCHAIN = 0;
   localparam int UNPK_TABLE    = 1;

endpackage

// File: rtl/tcodec_pack.sv
module tcodec_pack
   import tcodec_pkg::*;
#(
   parameter int TRITS  = 5,
   parameter int BYTE_W = 8
) (
   input  logic [2*TRITS-1:0] grp_i,
   output logic [BYTE_W-1:0]  byte_o,
   output logic               err_o
);

   localparam int GRP_W = 2 * TRITS;

   logic [TRITS-1:0]  bad;
   logic [BYTE_W-1:0] acc;

   // per-trit illegal code detection
   for (genvar i = 0; i < TRITS; i++) begin : g_bad
      assign bad[i] = (grp_i[2*i +: 2] == TC_BAD);
   end

   // multiply-by-3 and add, first trit most significant
   always_comb begin
      acc = '0;
      for (int i = 0; i < TRITS; i++) begin
         acc = acc * BYTE_W'(3) + {{(BYTE_W-2){1'b0}}, grp_i[2*i +: 2]};
      end
   end

   assign err_o  = |bad;
   assign byte_o = err_o ? '0 : acc;

   if (GRP_W < 2) begin : g_chk_w
      $error("tcodec_pack: group width too small");
   end

endmodule

// File: rtl/tcodec_unpack.sv
module tcodec_unpack
   import tcodec_pkg::*;
#(
   parameter int TRITS  = 5,
   parameter int BYTE_W = 8,
   parameter int IMPL   = UNPK_DIVCHAIN
) (
   input  logic [BYTE_W-1:0]  byte_i,
   output logic [2*TRITS-1:0] grp_o,
   output logic               err_o
);

   localparam int GRP_W  = 2 * TRITS;
   localparam int DEPTH  = 3 ** TRITS;
   localparam int MAXV   = DEPTH - 1;
   localparam int IDX_W  = $clog2(DEPTH);
   localparam logic [GRP_W-1:0] ZERO_GRP = {TRITS{TC_ZERO}};

   logic [GRP_W-1:0] raw;

   assign err_o = (byte_i > BYTE_W'(MAXV));

   if (IMPL == UNPK_DIVCHAIN) begin : g_div
      logic [BYTE_W-1:0] q;
      always_comb begin
         q   = byte_i;
         raw = '0;
         for (int k = TRITS - 1; k >= 0; k--) begin
            raw[2*k +: 2] = 2'(q % BYTE_W'(3));
            q             = q / BYTE_W'(3);
         end
      end
   end else begin : g_tab
      function automatic logic [GRP_W-1:0] grp_of(input int v);
         logic [GRP_W-1:0] g;
         int               r;
         g = '0;
         r = v;
         for (int k = TRITS - 1; k >= 0; k--) begin
            g[2*k +: 2] = 2'(r % 3);
            r           = r / 3;
         end
         return g;
      endfunction

      logic [GRP_W-1:0] lut [DEPTH];
      logic [IDX_W-1:0] idx;

      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         assign lut[e] = grp_of(e);
      end

      assign idx = err_o ? '0 : IDX_W'(byte_i);
      assign raw = lut[idx];
   end

   assign grp_o = err_o ? ZERO_GRP : raw;

   if (IMPL != UNPK_DIVCHAIN && IMPL != UNPK_TABLE) begin : g_chk_impl
      $error("tcodec_unpack: unknown IMPL value");
   end

endmodule

// File: rtl/tcodec_slot.sv
module tcodec_slot #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);

   logic         full_q;
   logic [W-1:0] data_q;

   assign in_ready  = !full_q || out_ready;
   assign out_valid = full_q;
   assign out_data  = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (in_valid && in_ready) begin
         full_q <= 1'b1;
         data_q <= in_data;
      end else if (out_ready) begin
         full_q <= 1'b0;
      end
   end

endmodule

// File: rtl/tcodec_bridge.sv
module tcodec_bridge
   import tcodec_pkg::*;
#(
   parameter int TRITS       = 5,
   parameter int BYTE_W      = 8,
   parameter int UNPACK_IMPL = UNPK_DIVCHAIN
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tg_in_valid,
   output logic                 tg_in_ready,
   input  logic [2*TRITS-1:0]   tg_in,
   output logic                 byte_out_valid,
   input  logic                 byte_out_ready,
   output logic [BYTE_W-1:0]    byte_out,
   output logic                 byte_out_err,
   input  logic                 byte_in_valid,
   output logic                 byte_in_ready,
   input  logic [BYTE_W-1:0]    byte_in,
   output logic                 tg_out_valid,
   input  logic                 tg_out_ready,
   output logic [2*TRITS-1:0]   tg_out,
   output logic                 tg_out_err
);

   localparam int GRP_W  = 2 * TRITS;
   localparam int PK_W   = BYTE_W + 1;
   localparam int UP_W   = GRP_W + 1;

   // elaboration-time parameter checks
   if (TRITS < 1) begin : g_chk_trits
      $error("tcodec_bridge: TRITS must be at least 1");
   end
   if (BYTE_W < 3) begin : g_chk_bw
      $error("tcodec_bridge: BYTE_W must be at least 3");
   end
   if ((3 ** TRITS) > (2 ** BYTE_W)) begin : g_chk_fit
      $error("tcodec_bridge: group does not fit in BYTE_W bits");
   end

   // pack channel
   logic [BYTE_W-1:0] pk_byte;
   logic              pk_err;
   logic [PK_W-1:0]   pk_res;

   tcodec_pack #(.TRITS(TRITS), .BYTE_W(BYTE_W)) u_pack (
      .grp_i  (tg_in),
      .byte_o (pk_byte),
      .err_o  (pk_err)
   );

   tcodec_slot #(.W(PK_W)) u_pk_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (tg_in_valid),
      .in_ready  (tg_in_ready),
      .in_data   ({pk_err, pk_byte}),
      .out_valid (byte_out_valid),
      .out_ready (byte_out_ready),
      .out_data  (pk_res)
   );

   assign byte_out     = pk_res[BYTE_W-1:0];
   assign byte_out_err = pk_res[BYTE_W];

   // unpack channel
   logic [GRP_W-1:0] up_grp;
   logic             up_err;
   logic [UP_W-1:0]  up_res;

   tcodec_unpack #(.TRITS(TRITS), .BYTE_W(BYTE_W), .IMPL(UNPACK_IMPL)) u_unpack (
      .byte_i (byte_in),
      .grp_o  (up_grp),
      .err_o  (up_err)
   );

   tcodec_slot #(.W(UP_W)) u_up_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (byte_in_valid),
      .in_ready  (byte_in_ready),
      .in_data   ({up_err, up_grp}),
      .out_valid (tg_out_valid),
      .out_ready (tg_out_ready),
      .out_data  (up_res)
   );

   assign tg_out     = up_res[GRP_W-1:0];
   assign tg_out_err = up_res[GRP_W];

endmodule

// File: rtl/tcodec_bridge_chk.sv
module tcodec_bridge_chk #(
   parameter int TRITS  = 5,
   parameter int BYTE_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tg_in_ready,
   input logic               byte_out_valid,
   input logic               byte_out_ready,
   input logic [BYTE_W-1:0]  byte_out,
   input logic               byte_out_err,
   input logic               byte_in_ready,
   input logic               tg_out_valid,
   input logic               tg_out_ready,
   input logic [2*TRITS-1:0] tg_out,
   input logic               tg_out_err
);

   localparam int MAXV = 3 ** TRITS - 1;
   localparam logic [2*TRITS-1:0] ZERO_GRP = {TRITS{2'b01}};

   function automatic logic has_bad(input logic [2*TRITS-1:0] g);
      logic b;
      b = 1'b0;
      for (int i = 0; i < TRITS; i++) b = b | (g[2*i +: 2] == 2'b11);
      return b;
   endfunction

   // R1: legal pack result lies inside the group code range
   p_pack_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_out_valid && !byte_out_err) |-> (byte_out <= BYTE_W'(MAXV)));

   // R2: flagged pack result carries a zero byte
   p_pack_bad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_out_valid && byte_out_err) |-> (byte_out == '0));

   // R3: legal unpack result uses only legal codes
   p_unpack_codes_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tg_out_valid && !tg_out_err) |-> !has_bad(tg_out));

   // R4: flagged unpack result is all-zero trits
   p_unpack_bad_zeros_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tg_out_valid && tg_out_err) |-> (tg_out == ZERO_GRP));

   // R5: held outputs stay put under backpressure
   p_pack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_out_valid && !byte_out_ready) |=>
         (byte_out_valid && $stable(byte_out) && $stable(byte_out_err)));

   p_unpack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tg_out_valid && !tg_out_ready) |=>
         (tg_out_valid && $stable(tg_out) && $stable(tg_out_err)));

   // R6: a full, stalled channel refuses input; an empty one accepts
   p_pack_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_out_valid && !byte_out_ready) |-> !tg_in_ready);

   p_unpack_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tg_out_valid && !tg_out_ready) |-> !byte_in_ready);

   p_pack_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_out_valid |-> tg_in_ready);

   // R8: reset empties both channels
   p_reset_r8: assert property (@(posedge clk)
      !rst_n |=> (!byte_out_valid && !tg_out_valid));

endmodule

bind tcodec_bridge tcodec_bridge_chk #(.TRITS(TRITS), .BYTE_W(BYTE_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .tg_in_ready    (tg_in_ready),
   .byte_out_valid (byte_out_valid),
   .byte_out_ready (byte_out_ready),
   .byte_out       (byte_out),
   .byte_out_err   (byte_out_err),
   .byte_in_ready  (byte_in_ready),
   .tg_out_valid   (tg_out_valid),
   .tg_out_ready   (tg_out_ready),
   .tg_out         (tg_out),
   .tg_out_err     (tg_out_err)
);

// File: tb/tcodec_bridge_test.sv
module tcodec_bridge_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tg_in_valid = 1'b0;
   logic       tg_in_ready;
   logic [9:0] tg_in = '0;
   logic       byte_out_valid;
   logic       byte_out_ready = 1'b1;
   logic [7:0] byte_out;
   logic       byte_out_err;
   logic       byte_in_valid = 1'b0;
   logic       byte_in_ready;
   logic [7:0] byte_in = '0;
   logic       tg_out_valid;
   logic       tg_out_ready = 1'b1;
   logic [9:0] tg_out;
   logic       tg_out_err;

   always #4 clk = ~clk;

   tcodec_bridge uut (
      .clk(clk), .rst_n(rst_n),
      .tg_in_valid(tg_in_valid), .tg_in_ready(tg_in_ready), .tg_in(tg_in),
      .byte_out_valid(byte_out_valid), .byte_out_ready(byte_out_ready),
      .byte_out(byte_out), .byte_out_err(byte_out_err),
      .byte_in_valid(byte_in_valid), .byte_in_ready(byte_in_ready), .byte_in(byte_in),
      .tg_out_valid(tg_out_valid), .tg_out_ready(tg_out_ready),
      .tg_out(tg_out), .tg_out_err(tg_out_err)
   );

   int n_chk = 0;
   int n_fail = 0;
   int pk_mode = 0;   // 0 ready, 1 irregular, 2 stalled
   int up_mode = 0;
   bit done = 1'b0;

   logic [9:0] grp_tab [243];
   logic [8:0] pk_q [$];
   logic [10:0] up_q [$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // ready generation
   always @(negedge clk) begin
      byte_out_ready <= (pk_mode == 0) ? 1'b1 : (pk_mode == 1) ? ($urandom_range(3) != 0) : 1'b0;
      tg_out_ready   <= (up_mode == 0) ? 1'b1 : (up_mode == 1) ? ($urandom_range(2) != 0) : 1'b0;
   end

   // pack monitor
   bit         pk_stall_prev = 1'b0;
   logic [8:0] pk_prev = '0;
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (pk_stall_prev)
            chk(byte_out_valid && {byte_out_err, byte_out} == pk_prev, "R5 pack hold",
                {23'd0, byte_out_err, byte_out}, {23'd0, pk_prev});
         if (byte_out_valid && byte_out_ready) begin
            if (pk_q.size() == 0) chk(1'b0, "R6 pack extra output", {24'd0, byte_out}, 32'd0);
            else begin
               logic [8:0] e;
               e = pk_q.pop_front();
               chk({byte_out_err, byte_out} == e, e[8] ? "R2 pack illegal" : "R1 pack value",
                   {23'd0, byte_out_err, byte_out}, {23'd0, e});
            end
         end
         pk_stall_prev = byte_out_valid && !byte_out_ready;
         pk_prev = {byte_out_err, byte_out};
      end
   end

   // unpack monitor
   bit          up_stall_prev = 1'b0;
   logic [10:0] up_prev = '0;
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (up_stall_prev)
            chk(tg_out_valid && {tg_out_err, tg_out} == up_prev, "R5 unpack hold",
                {21'd0, tg_out_err, tg_out}, {21'd0, up_prev});
         if (tg_out_valid && tg_out_ready) begin
            if (up_q.size() == 0) chk(1'b0, "R6 unpack extra output", {22'd0, tg_out}, 32'd0);
            else begin
               logic [10:0] e;
               e = up_q.pop_front();
               chk({tg_out_err, tg_out} == e, e[10] ? "R4 unpack range" : "R3 unpack value",
                   {21'd0, tg_out_err, tg_out}, {21'd0, e});
            end
         end
         up_stall_prev = tg_out_valid && !tg_out_ready;
         up_prev = {tg_out_err, tg_out};
      end
   end

   task automatic send_pk(input logic [9:0] g, input logic [7:0] eb, input logic ee);
      pk_q.push_back({ee, eb});
      @(negedge clk);
      tg_in_valid = 1'b1;
      tg_in = g;
      forever begin
         #2;
         if (tg_in_ready) begin
            @(posedge clk);
            break;
         end
         @(negedge clk);
      end
      #1 tg_in_valid = 1'b0;
   endtask

   task automatic send_ub(input logic [7:0] b);
      if (b > 8'd242) up_q.push_back({1'b1, 10'h155});
      else up_q.push_back({1'b0, grp_tab[b]});
      @(negedge clk);
      byte_in_valid = 1'b1;
      byte_in = b;
      forever begin
         #2;
         if (byte_in_ready) begin
            @(posedge clk);
            break;
         end
         @(negedge clk);
      end
      #1 byte_in_valid = 1'b0;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      // group table in counting order: trit 0 is the most significant digit
      begin
         int n;
         n = 0;
         for (int a = 0; a < 3; a++)
            for (int b = 0; b < 3; b++)
               for (int c = 0; c < 3; c++)
                  for (int d = 0; d < 3; d++)
                     for (int e = 0; e < 3; e++) begin
                        grp_tab[n] = {2'(e), 2'(d), 2'(c), 2'(b), 2'(a)};
                        n++;
                     end
      end

      // R8: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!byte_out_valid && !tg_out_valid, "R8 reset valids", {30'd0, byte_out_valid, tg_out_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      #2 chk(!byte_out_valid && !tg_out_valid, "R8 first cycle", {30'd0, byte_out_valid, tg_out_valid}, 32'd0);

      // R9 and R6: latency into an empty channel, then stall
      pk_mode = 2;
      pk_q.push_back({1'b0, 8'd100});
      @(negedge clk);
      #2 chk(!byte_out_valid, "R9 before accept", {31'd0, byte_out_valid}, 32'd0);
      tg_in_valid = 1'b1;
      tg_in = grp_tab[100];
      #1 chk(tg_in_ready, "R6 empty slot accepts", {31'd0, tg_in_ready}, 32'd1);
      @(posedge clk);
      #1 tg_in_valid = 1'b0;
      @(negedge clk);
      #2 chk(byte_out_valid && byte_out == 8'd100, "R9 one cycle latency",
             {23'd0, byte_out_valid, byte_out}, {23'd0, 1'b1, 8'd100});

      fork
         send_pk(grp_tab[7], 8'd7, 1'b0);
      join_none
      repeat (5) begin
         @(negedge clk);
         #2 chk(!tg_in_ready, "R6 full slot refuses", {31'd0, tg_in_ready}, 32'd0);
      end

      // R7: unpack runs while pack is stalled
      for (int b = 0; b < 20; b++) send_ub(8'(b * 13));
      repeat (3) @(negedge clk);
      chk(up_q.size() == 0, "R7 unpack drained during pack stall", up_q.size(), 32'd0);
      chk(pk_q.size() == 2, "R7 pack still held", pk_q.size(), 32'd2);

      pk_mode = 1;
      wait fork;
      up_mode = 1;

      // exhaustive sweeps under irregular backpressure
      fork
         begin
            for (int n = 0; n < 243; n++) send_pk(grp_tab[n], 8'(n), 1'b0);
            for (int p = 0; p < 5; p++) begin
               logic [9:0] g;
               g = grp_tab[(p * 47 + 11) % 243];
               g[2*p +: 2] = 2'b11;
               send_pk(g, 8'd0, 1'b1);
            end
            send_pk(10'h3FF, 8'd0, 1'b1);
         end
         begin
            for (int b = 0; b < 256; b++) send_ub(8'(b));
         end
      join

      pk_mode = 0;
      up_mode = 0;
      repeat (10) @(negedge clk);
      chk(pk_q.size() == 0, "R6 pack all results delivered", pk_q.size(), 32'd0);
      chk(up_q.size() == 0, "R6 unpack all results delivered", up_q.size(), 32'd0);

      done = 1'b1;
      finish_run();
   end

endmodule